// File: doc/BRIEF.md
# Rejected-Access Runout Log

This block keeps a circular error log of command-submission writes that the pusher refused. Each refused access arrives on a valid/ready strobe with its address, channel number and data. The block writes it as an 8-byte record into a backing RAM: the address-and-channel word first, then the data word on the next cycle. It then moves its put pointer forward by one record. Software drains the log by reading records from the RAM and writing a new get pointer through the register port.

A configuration word places the log on any 0x200-byte boundary of a 64 KiB window and selects one of two capacities, 64 or 1024 records. When the ring is full, a refused access is dropped without touching the RAM, and a separate overflow flag is raised. Both flags are pending bits with write-1-to-clear acknowledge and a per-bit enable that gates a single interrupt line. A unit-level enable input, when low, returns the enables and the configuration to their defaults.

Top module: `runout_logger`

## Requirements
- R1: After reset, pending and enable registers read 0, the configuration reads 0x1e00, put and get read 0, the status register reads empty (bit 0 set, bit 1 clear) and `irq_o` is low.
- R2: A refused access is taken when `rej_valid` and `rej_ready` are both high at a clock edge. `rej_ready` is low for the next two cycles while the record is written. In the first of those cycles the RAM receives word 0 (address in bits 12:0, channel in bits 30:24, other bits zero) at the record address. In the second it receives the data at the record address plus 4.
- R3: Each written record advances put by one, modulo the capacity, and sets the logged pending bit (bit 4). Put changes for no other reason.
- R4: The ring is full when (put+1) modulo capacity equals get. An access taken while full causes no RAM write and no put change, and it sets the overflow pending bit (bit 8).
- R5: Configuration bit 16 selects the capacity: 0 gives 64 records and 1 gives 1024 records. Pointers wrap at that capacity.
- R6: The record address is base + 8 × put (modulo 64 KiB), where base holds configuration bits 15:9 with bits 8:0 zero.
- R7: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: A pending bit shows in the pending register whether or not it is enabled. `irq_o` is high exactly when some pending bit has its enable bit set.
- R9: While `unit_en` is low, the enable register is held at 0 and the configuration at 0x1e00, and register writes to them are ignored. Pending bits and pointers are kept.
- R10: Register map (word index on `reg_addr`): 0 pending, 1 enable, 2 configuration, 3 status (bit 0 empty, bit 1 full), 4 put (read-only), 5 get (writable, masked to capacity−1). Unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Unit enable; low forces defaults |
| rej_valid | input | 1 | A refused access is offered |
| rej_ready | output | 1 | Logger can take an access |
| rej_addr | input | REJ_ADDR_W | Address of the refused access |
| rej_chid | input | CHID_W | Channel of the refused access |
| rej_data | input | 32 | Data of the refused access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | MEM_AW | RAM byte address |
| mem_wdata | output | 32 | RAM write data |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions check, on every cycle, that put moves only on a completed record, that a dropped access never writes the RAM, that the data word follows the address word at +4, that a zero write leaves pending bits standing, and that a low unit enable quiets the line and restores the configuration. Only the bench scenarios can show the record contents and addresses, the full threshold for each capacity, wrap-around, and what the register reads return after filling, draining and disabling.

// File: rtl/runout_pkg.sv
package runout_pkg;
  localparam int BIT_LOGGED  = 4;
  localparam int BIT_DROPPED = 8;
  localparam int CHID_LSB    = 24;
  localparam int BASE_LSB    = 9;
  localparam int BASE_MSB    = 15;
  localparam int SIZE_BIT    = 16;
  localparam logic [31:0] CFG_DEFAULT = 32'h0000_1e00;
  localparam logic [31:0] IRQ_IMPL = (32'd1 << BIT_LOGGED) | (32'd1 << BIT_DROPPED);

  typedef enum logic [2:0] {
    RA_PEND = 3'd0, RA_MASK = 3'd1, RA_CFG = 3'd2,
    RA_STAT = 3'd3, RA_PUT  = 3'd4, RA_GET = 3'd5
  } reg_idx_e;

  typedef enum logic [1:0] {WR_IDLE = 2'd0, WR_FIRST = 2'd1, WR_SECOND = 2'd2} wr_state_e;

  // next ring index under a power-of-two wrap mask
  function automatic logic [31:0] ring_step(logic [31:0] idx, logic [31:0] wrap);
    return (idx + 32'd1) & wrap;
  endfunction

  // byte address of a record slot
  function automatic logic [31:0] slot_byte(logic [31:0] base, logic [31:0] idx);
    return base + (idx << 3);
  endfunction

  // address-and-channel word of a record
  function automatic logic [31:0] pack_first(logic [31:0] addr, logic [31:0] chid);
    return addr | (chid << CHID_LSB);
  endfunction
endpackage

// File: rtl/runout_ring.sv
module runout_ring
  import runout_pkg::*;
#(
  parameter int IDX_W      = 10,
  parameter int SMALL_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             large_mode,
  input  logic             advance,
  input  logic             get_we,
  input  logic [IDX_W-1:0] get_wdata,
  output logic [IDX_W-1:0] put_o,
  output logic [IDX_W-1:0] get_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [31:0] LARGE_WRAP = (32'd1 << IDX_W) - 32'd1;
  localparam logic [31:0] SMALL_WRAP = (32'd1 << SMALL_LOG2) - 32'd1;

  logic [IDX_W-1:0] put_q, get_q, wrap;
  logic [31:0]      put_next;

  assign wrap     = large_mode ? IDX_W'(LARGE_WRAP) : IDX_W'(SMALL_WRAP);
  assign put_o    = put_q & wrap;
  assign get_o    = get_q & wrap;
  assign put_next = ring_step(32'(put_o), 32'(wrap));
  assign empty_o  = (put_o == get_o);
  assign full_o   = (IDX_W'(put_next) == get_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      put_q <= '0;
      get_q <= '0;
    end else begin
      if (advance) put_q <= IDX_W'(put_next);
      if (get_we)  get_q <= get_wdata & wrap;
    end
  end

  // R3: put only moves on a completed record
  a_r3_put_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(put_q));
endmodule

// File: rtl/runout_writer.sv
module runout_writer
  import runout_pkg::*;
#(
  parameter int MEM_AW     = 16,
  parameter int IDX_W      = 10,
  parameter int REJ_ADDR_W = 13,
  parameter int CHID_W     = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rej_valid,
  output logic                  rej_ready,
  input  logic [REJ_ADDR_W-1:0] rej_addr,
  input  logic [CHID_W-1:0]     rej_chid,
  input  logic [31:0]           rej_data,
  input  logic                  ring_full,
  input  logic [IDX_W-1:0]      slot_idx,
  input  logic [MEM_AW-1:0]     base_addr,
  output logic                  mem_we,
  output logic [MEM_AW-1:0]     mem_addr,
  output logic [31:0]           mem_wdata,
  output logic                  ev_logged,
  output logic                  ev_drop
);
  wr_state_e         state_q;
  logic [31:0]       first_q, second_q;
  logic [MEM_AW-1:0] slot_q;
  logic              take;

  assign rej_ready = (state_q == WR_IDLE);
  assign take      = rej_valid && rej_ready;
  assign ev_drop   = take && ring_full;
  assign ev_logged = (state_q == WR_SECOND);
  assign mem_we    = (state_q != WR_IDLE);
  assign mem_addr  = (state_q == WR_SECOND) ? MEM_AW'(slot_q + MEM_AW'(4)) : slot_q;
  assign mem_wdata = (state_q == WR_FIRST) ? first_q : second_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= WR_IDLE;
      first_q  <= '0;
      second_q <= '0;
      slot_q   <= '0;
    end else begin
      unique case (state_q)
        WR_IDLE: if (take && !ring_full) begin
          state_q  <= WR_FIRST;
          first_q  <= pack_first(32'(rej_addr), 32'(rej_chid));
          second_q <= rej_data;
          slot_q   <= MEM_AW'(slot_byte(32'(base_addr), 32'(slot_idx)));
        end
        WR_FIRST:  state_q <= WR_SECOND;
        WR_SECOND: state_q <= WR_IDLE;
        default:   state_q <= WR_IDLE;
      endcase
    end
  end

  // R4: a dropped access never reaches the RAM
  a_r4_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !mem_we);
  // R2: data word follows the address word at +4
  a_r2_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !ev_logged) |=> (mem_we && mem_addr == MEM_AW'($past(mem_addr) + MEM_AW'(4))));
endmodule

// File: rtl/runout_irq.sv
module runout_irq
  import runout_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unit_en,
  input  logic        set_logged,
  input  logic        set_dropped,
  input  logic        pend_we,
  input  logic        mask_we,
  input  logic [31:0] wdata,
  output logic [31:0] pend_o,
  output logic [31:0] mask_o,
  output logic        irq_o
);
  logic [31:0] pend_q, mask_q, sets, acks;

  assign sets   = (set_logged  ? (32'd1 << BIT_LOGGED)  : 32'd0)
                | (set_dropped ? (32'd1 << BIT_DROPPED) : 32'd0);
  assign acks   = pend_we ? (wdata & IRQ_IMPL) : 32'd0;
  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~acks) | sets;
      if (!unit_en)     mask_q <= '0;
      else if (mask_we) mask_q <= wdata & IRQ_IMPL;
    end
  end

  // R9: disabled unit quiets the line
  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> !irq_o);
  // R3: logged flag rises only from a completed record
  a_r3_logged_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o[BIT_LOGGED]) |-> $past(set_logged));
  // R7: writing zeros keeps every pending bit
  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_we && (wdata & IRQ_IMPL) == 32'd0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/runout_logger.sv
module runout_logger
  import runout_pkg::*;
#(
  parameter int IDX_W      = 10,
  parameter int SMALL_LOG2 = 6,
  parameter int REJ_ADDR_W = 13,
  parameter int CHID_W     = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  unit_en,
  input  logic                  rej_valid,
  output logic                  rej_ready,
  input  logic [REJ_ADDR_W-1:0] rej_addr,
  input  logic [CHID_W-1:0]     rej_chid,
  input  logic [31:0]           rej_data,
  input  logic                  reg_wr,
  input  logic [2:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  mem_we,
  output logic [15:0]           mem_addr,
  output logic [31:0]           mem_wdata,
  output logic                  irq_o
);
  localparam int MEM_AW  = BASE_MSB + 1;
  localparam int BASE_W  = BASE_MSB - BASE_LSB + 1;

  logic [BASE_W-1:0] base_q;
  logic              large_q;
  logic [MEM_AW-1:0] base_addr;
  logic [IDX_W-1:0]  put_idx, get_idx;
  logic              empty, full, ev_logged, ev_drop;
  logic [31:0]       pend, mask, cfg_view;
  logic              wr_pend, wr_mask, wr_cfg, wr_get;

  assign wr_pend   = reg_wr && (reg_addr == RA_PEND);
  assign wr_mask   = reg_wr && (reg_addr == RA_MASK);
  assign wr_cfg    = reg_wr && (reg_addr == RA_CFG);
  assign wr_get    = reg_wr && (reg_addr == RA_GET);
  assign base_addr = {base_q, {BASE_LSB{1'b0}}};
  assign cfg_view  = (32'(large_q) << SIZE_BIT) | 32'(base_addr);

  always_ff @(posedge clk) begin
    if (!rst_n || !unit_en) begin
      base_q  <= CFG_DEFAULT[BASE_MSB:BASE_LSB];
      large_q <= CFG_DEFAULT[SIZE_BIT];
    end else if (wr_cfg) begin
      base_q  <= reg_wdata[BASE_MSB:BASE_LSB];
      large_q <= reg_wdata[SIZE_BIT];
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_PEND: reg_rdata = pend;
      RA_MASK: reg_rdata = mask;
      RA_CFG:  reg_rdata = cfg_view;
      RA_STAT: reg_rdata = {30'd0, full, empty};
      RA_PUT:  reg_rdata = 32'(put_idx);
      RA_GET:  reg_rdata = 32'(get_idx);
      default: reg_rdata = 32'd0;
    endcase
  end

  runout_ring #(.IDX_W(IDX_W), .SMALL_LOG2(SMALL_LOG2)) u_ring (
    .clk(clk), .rst_n(rst_n), .large_mode(large_q), .advance(ev_logged),
    .get_we(wr_get), .get_wdata(reg_wdata[IDX_W-1:0]),
    .put_o(put_idx), .get_o(get_idx), .empty_o(empty), .full_o(full)
  );

  runout_writer #(.MEM_AW(MEM_AW), .IDX_W(IDX_W), .REJ_ADDR_W(REJ_ADDR_W), .CHID_W(CHID_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .rej_valid(rej_valid), .rej_ready(rej_ready),
    .rej_addr(rej_addr), .rej_chid(rej_chid), .rej_data(rej_data),
    .ring_full(full), .slot_idx(put_idx), .base_addr(base_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ev_logged(ev_logged), .ev_drop(ev_drop)
  );

  runout_irq u_irq (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
    .set_logged(ev_logged), .set_dropped(ev_drop),
    .pend_we(wr_pend), .mask_we(wr_mask), .wdata(reg_wdata),
    .pend_o(pend), .mask_o(mask), .irq_o(irq_o)
  );

  // R9: configuration back at default one cycle after disable
  a_r9_cfg_default: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> (cfg_view == CFG_DEFAULT));
  // R4: dropped access raises the overflow flag
  a_r4_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> pend[BIT_DROPPED]);
endmodule

// File: tb/runout_logger_tb.sv
module runout_logger_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, unit_en = 1;
  logic        rej_valid = 0, rej_ready;
  logic [12:0] rej_addr = '0;
  logic [6:0]  rej_chid = '0;
  logic [31:0] rej_data = '0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_we, irq_o;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;

  int checks = 0, errors = 0, wcount = 0;
  logic [31:0] ram [int];
  logic        ready_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  runout_logger u_dut (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
    .rej_valid(rej_valid), .rej_ready(rej_ready), .rej_addr(rej_addr),
    .rej_chid(rej_chid), .rej_data(rej_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_o(irq_o)
  );

  always @(posedge clk) if (mem_we) begin
    ram[int'(mem_addr)] = mem_wdata;
    wcount++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] word0(input logic [12:0] a, input logic [6:0] c);
    return {1'b0, c, 11'd0, a};
  endfunction

  task automatic reject(input logic [12:0] a, input logic [6:0] c, input logic [31:0] d);
    @(negedge clk);
    rej_valid = 1; rej_addr = a; rej_chid = c; rej_data = d;
    @(negedge clk);
    rej_valid = 0;
    ready_seen = rej_ready;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 pend", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    rd(2, v); chk("R1 cfg", v, 32'h1e00);
    rd(3, v); chk("R1 stat", v, 32'h1);
    rd(4, v); chk("R1 put", v, 0);
    rd(5, v); chk("R1 get", v, 0);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    reject(13'h123, 7'd5, 32'hdeadbeef);
    chk("R2 ready low while writing", 32'(ready_seen), 0);
    chk("R2 word0", ram[32'h1e00], word0(13'h123, 7'd5));
    chk("R2 word1", ram[32'h1e04], 32'hdeadbeef);
    chk("R2 two writes", 32'(wcount), 2);
    rd(4, v); chk("R3 put advance", v, 1);
    rd(0, v); chk("R3 logged bit", v, 32'h10);
    rd(3, v); chk("R10 not empty", v, 0);
    chk("R8 masked keeps irq low", 32'(irq_o), 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(1, 32'hffff_ffff);
    rd(1, v); chk("R10 mask readback", v, 32'h110);
    chk("R8 enabled pending drives irq", 32'(irq_o), 1);
    wr(0, 32'h0);
    rd(0, v); chk("R7 zero write keeps", v, 32'h10);
    wr(0, 32'h10);
    rd(0, v); chk("R7 one write clears", v, 0);
    chk("R8 irq drops", 32'(irq_o), 0);
  endtask

  task automatic t_small_full();
    logic [31:0] v;
    int w;
    wr(5, 1);
    rd(3, v); chk("R10 empty after get", v, 1);
    for (int i = 0; i < 63; i++) reject(13'(i), 7'd1, 32'h100 + 32'(i));
    rd(4, v); chk("R5 small wrap put", v, 0);
    rd(3, v); chk("R4 full flag", v, 2);
    chk("R6 slot 63 addr", ram[32'h1e00 + 63*8 + 4], 32'h100 + 32'd62);
    wr(0, 32'h110);
    w = wcount;
    reject(13'h7, 7'd2, 32'h5555);
    chk("R4 drop no write", 32'(wcount), 32'(w));
    chk("R4 ready stays high", 32'(ready_seen), 1);
    rd(4, v); chk("R4 put unchanged", v, 0);
    rd(0, v); chk("R4 overflow bit", v, 32'h100);
    chk("R8 overflow irq", 32'(irq_o), 1);
    wr(0, 32'h100);
    wr(5, 2);
    reject(13'h9, 7'd3, 32'h6666);
    chk("R5 wrapped slot 0", ram[32'h1e04], 32'h6666);
    rd(4, v); chk("R3 put after wrap", v, 1);
  endtask

  task automatic t_large();
    logic [31:0] v;
    wr(2, 32'h0001_4000);
    rd(2, v); chk("R5 cfg large", v, 32'h0001_4000);
    rd(3, v); chk("R4 full in large when put+1==get", v, 2);
    wr(5, 1);
    for (int i = 0; i < 1023; i++) reject(13'(i), 7'd9, 32'h2000 + 32'(i));
    rd(4, v); chk("R5 large wrap put", v, 0);
    rd(3, v); chk("R5 large full", v, 2);
    chk("R6 last record word0", ram[32'h5ff8], word0(13'd1022, 7'd9));
    chk("R6 last record data", ram[32'h5ffc], 32'h2000 + 32'd1022);
    chk("R6 first large record", ram[32'h4008], word0(13'd0, 7'd9));
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(1, 32'h110);
    wr(0, 32'h110);
    reject(13'h1, 7'd0, 32'h1);
    rd(0, v); chk("R4 overflow again", v, 32'h100);
    @(negedge clk); unit_en = 0;
    @(negedge clk);
    rd(2, v); chk("R9 cfg forced", v, 32'h1e00);
    rd(1, v); chk("R9 mask forced", v, 0);
    chk("R9 irq low", 32'(irq_o), 0);
    wr(2, 32'h0001_8000);
    wr(1, 32'h110);
    rd(2, v); chk("R9 cfg write ignored", v, 32'h1e00);
    rd(1, v); chk("R9 mask write ignored", v, 0);
    rd(0, v); chk("R9 pending kept", v, 32'h100);
    rd(5, v); chk("R9 get kept", v, 1);
    unit_en = 1;
    @(negedge clk);
    rd(2, v); chk("R9 cfg stays default", v, 32'h1e00);
    rd(7, v); chk("R10 unused index", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_irq();
    t_small_full();
    t_large();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule